// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for each incoming frame, whether the receive path should keep it. It looks at the 48-bit destination address and the frame length in bytes. Three mode bits and a minimum length control the decision: promiscuous mode, a broadcast veto and a multicast enable. It returns one registered verdict per request: an accept bit, a group flag that marks accepted broadcast and multicast frames, and a 4-bit reason code that says which rule decided.

The filter holds two kinds of state. The first is a station address, written in one cycle. The second is a multicast hash table of 2^HASH_BITS bins. Software rebuilds the table by streaming a list of addresses into the block, one byte per cycle. The loader runs the Ethernet CRC-32 over each 6-byte address, one byte per cycle, and sets the bin that the CRC selects. A request is compared against the table as it stands at the clock edge where the request is taken.

The address byte order is fixed. Byte 0, the first byte on the wire, sits in bits [7:0] of an address bus. Byte k sits in bits [8k+7:8k].

Top module: `rx_addr_filter`

## Requirements
- R1: `res_valid` rises in the cycle after each cycle where `chk_valid` is high, and in no other cycle. It is low out of reset. `res_accept`, `res_group` and `res_reason` describe the request taken at that edge.
- R2: A frame with `chk_len` below `cfg_min_len` is rejected with reason 4 and group flag 0, whatever its address. The length test comes before every address rule.
- R3: If the length test passes and `cfg_promisc` is 1, the frame is accepted with reason 0 and group flag 0.
- R4: A destination of all 48 ones is broadcast. When `cfg_bcast_off` is 1 it is rejected with reason 5. Otherwise it is accepted with reason 1 and group flag 1.
- R5: Any other destination with bit 0 set (bit 0 of byte 0) is multicast. When `cfg_mcast_en` is 0 it is rejected with reason 6.
- R6: With `cfg_mcast_en` set, the loader computes a CRC over the 6 address bytes:
  - The CRC is reflected, with polynomial 0xEDB88320.
  - It starts from all ones and is not inverted at the end.
  - It takes byte 0 first, each byte least significant bit first.
  - CRC bits [7:2] form the bin index. Bin n is table byte n/8, bit n%8, which is flat bit n.
  - A frame whose bin is set is accepted with reason 2 and group flag 1. A frame whose bin is clear is rejected with reason 7.
- R7: Any other destination is accepted with reason 3 and group flag 0 only if it equals the station address. Otherwise it is rejected with reason 8. A write on `sta_wr` takes effect for requests from the next cycle onward.
- R8: `ml_start` clears every bin. The load then takes min(`ml_bytes`/6, 64) addresses, rounding the division down. Any bytes streamed after those addresses leave the table unchanged.
- R9: `ml_done` is high for exactly one cycle. That cycle follows the edge that takes the final byte of the last counted address. If the count is zero, it is the cycle after `ml_start`.
- R10: A request sees the table and station address as they were before its own edge. A bin set, or a clear, at that same edge affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cfg_promisc | input | 1 | Accept every frame of legal length |
| cfg_bcast_off | input | 1 | Reject broadcast frames |
| cfg_mcast_en | input | 1 | Allow multicast frames through the hash table |
| cfg_min_len | input | LEN_W | Minimum frame length in bytes |
| sta_wr | input | 1 | Load `sta_addr` into the station address |
| sta_addr | input | 48 | New station address, byte 0 in [7:0] |
| ml_start | input | 1 | Clear the table and begin a list load |
| ml_bytes | input | LIST_W | List length in bytes |
| ml_byte_valid | input | 1 | `ml_byte` carries the next list byte |
| ml_byte | input | 8 | List byte stream, address byte 0 first |
| ml_done | output | 1 | Pulse when the load has taken its last address |
| chk_valid | input | 1 | Filter request |
| chk_dst | input | 48 | Destination address, byte 0 in [7:0] |
| chk_len | input | LEN_W | Frame length in bytes |
| res_valid | output | 1 | Verdict present |
| res_accept | output | 1 | Frame accepted |
| res_group | output | 1 | Accepted broadcast or multicast |
| res_reason | output | 4 | Deciding rule, codes 0 to 8 as above |

## Verification
Two things can land on the same clock edge: a filter request for a multicast address, and the table update from the list loader, either setting that address's bin or clearing the whole table. The bench provokes both cases directly. In the first, it drives the sixth byte of an address together with a request for that same address. In the second, it drives `ml_start` together with a request for an address that is already loaded. The verdict must reflect the table from before that edge, and a repeat request one cycle later must reflect the new table. Random traffic across every address class and mode mix is then judged against a bench model of the rules and of the table contents.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [3:0] {
      RSN_PROMISC = 4'd0,
      RSN_BCAST   = 4'd1,
      RSN_MCAST   = 4'd2,
      RSN_UCAST   = 4'd3,
      RSN_SHORT   = 4'd4,
      RSN_BC_OFF  = 4'd5,
      RSN_MC_OFF  = 4'd6,
      RSN_MC_MISS = 4'd7,
      RSN_UC_MISS = 4'd8
   } reason_e;

   localparam logic [31:0] CRC_POLY = 32'hEDB88320;
   localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

   // One reflected CRC-32 step over a byte, LSB first
   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
         else             r = r >> 1;
      end
      return r;
   endfunction

   function automatic logic [31:0] crc_addr(input logic [47:0] a);
      logic [31:0] r;
      r = CRC_INIT;
      for (int k = 0; k < 6; k++) r = crc_step(r, a[8*k +: 8]);
      return r;
   endfunction

endpackage

// File: rtl/rxf_mcast_table.sv
module rxf_mcast_table
   import rxf_pkg::*;
#(
   parameter int LIST_W    = 16,
   parameter int MAX_ADDR  = 64,
   parameter int HASH_BITS = 6,
   parameter int HASH_LSB  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ml_start,
   input  logic [LIST_W-1:0]          ml_bytes,
   input  logic                       ml_byte_valid,
   input  logic [7:0]                 ml_byte,
   output logic                       ml_done,
   output logic [(1<<HASH_BITS)-1:0]  table_o
);
   localparam int TBL   = 1 << HASH_BITS;
   localparam int CNT_W = $clog2(MAX_ADDR + 1);

   logic [TBL-1:0]    tbl_q;
   logic [CNT_W-1:0]  left_q;
   logic [2:0]        bidx_q;
   logic [31:0]       crc_q;
   logic              busy_q;
   logic              done_q;

   logic [LIST_W-1:0] n_div;
   logic [CNT_W-1:0]  n_cap;
   logic [31:0]       crc_nxt;
   logic [HASH_BITS-1:0] bin;

   always_comb begin
      n_div = ml_bytes / LIST_W'(6);
      if (n_div > LIST_W'(MAX_ADDR)) n_cap = CNT_W'(MAX_ADDR);
      else                           n_cap = n_div[CNT_W-1:0];
      crc_nxt = crc_step(crc_q, ml_byte);
      bin     = crc_nxt[HASH_LSB +: HASH_BITS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbl_q  <= '0;
         left_q <= '0;
         bidx_q <= '0;
         crc_q  <= CRC_INIT;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (ml_start) begin
            tbl_q  <= '0;
            left_q <= n_cap;
            bidx_q <= '0;
            crc_q  <= CRC_INIT;
            busy_q <= (n_cap != '0);
            done_q <= (n_cap == '0);
         end else if (busy_q && ml_byte_valid) begin
            if (bidx_q == 3'd5) begin
               tbl_q[bin] <= 1'b1;
               crc_q      <= CRC_INIT;
               bidx_q     <= '0;
               left_q     <= left_q - 1'b1;
               if (left_q == CNT_W'(1)) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end else begin
               crc_q  <= crc_nxt;
               bidx_q <= bidx_q + 1'b1;
            end
         end
      end
   end

   assign table_o = tbl_q;
   assign ml_done = done_q;

endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
   import rxf_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int HASH_BITS = 6,
   parameter int HASH_LSB  = 2
) (
   input  logic [47:0]               dst,
   input  logic [LEN_W-1:0]          len,
   input  logic [LEN_W-1:0]          min_len,
   input  logic                      promisc,
   input  logic                      bcast_off,
   input  logic                      mcast_en,
   input  logic [47:0]               station,
   input  logic [(1<<HASH_BITS)-1:0] mc_table,
   output logic                      accept,
   output logic                      group,
   output reason_e                   reason
);
   logic [5:0]           byte_eq;
   logic [31:0]          crc;
   logic [HASH_BITS-1:0] hidx;
   logic                 is_bc;

   for (genvar i = 0; i < 6; i++) begin : g_cmp
      assign byte_eq[i] = (dst[8*i +: 8] == station[8*i +: 8]);
   end

   assign crc   = crc_addr(dst);
   assign hidx  = crc[HASH_LSB +: HASH_BITS];
   assign is_bc = &dst;

   always_comb begin
      accept = 1'b0;
      group  = 1'b0;
      reason = RSN_SHORT;
      if (len < min_len) begin
         reason = RSN_SHORT;
      end else if (promisc) begin
         accept = 1'b1;
         reason = RSN_PROMISC;
      end else if (is_bc) begin
         if (bcast_off) reason = RSN_BC_OFF;
         else begin
            accept = 1'b1;
            group  = 1'b1;
            reason = RSN_BCAST;
         end
      end else if (dst[0]) begin
         if (!mcast_en) reason = RSN_MC_OFF;
         else if (mc_table[hidx]) begin
            accept = 1'b1;
            group  = 1'b1;
            reason = RSN_MCAST;
         end else reason = RSN_MC_MISS;
      end else if (&byte_eq) begin
         accept = 1'b1;
         reason = RSN_UCAST;
      end else begin
         reason = RSN_UC_MISS;
      end
   end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxf_pkg::*;
#(
   parameter int          LEN_W     = 16,
   parameter int          LIST_W    = 16,
   parameter int          MAX_ADDR  = 64,
   parameter int          HASH_BITS = 6,
   parameter int          HASH_LSB  = 2,
   parameter logic [47:0] STA_RESET = 48'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_promisc,
   input  logic              cfg_bcast_off,
   input  logic              cfg_mcast_en,
   input  logic [LEN_W-1:0]  cfg_min_len,
   input  logic              sta_wr,
   input  logic [47:0]       sta_addr,
   input  logic              ml_start,
   input  logic [LIST_W-1:0] ml_bytes,
   input  logic              ml_byte_valid,
   input  logic [7:0]        ml_byte,
   output logic              ml_done,
   input  logic              chk_valid,
   input  logic [47:0]       chk_dst,
   input  logic [LEN_W-1:0]  chk_len,
   output logic              res_valid,
   output logic              res_accept,
   output logic              res_group,
   output logic [3:0]        res_reason
);
   localparam int TBL = 1 << HASH_BITS;

   if (HASH_LSB + HASH_BITS > 32) begin : g_bad_hash
      $error("hash slice exceeds the 32-bit CRC");
   end
   if (MAX_ADDR < 1 || (MAX_ADDR * 6) >= (1 << LIST_W)) begin : g_bad_list
      $error("MAX_ADDR must be at least 1 and fit a LIST_W byte count");
   end

   logic [47:0]    station_q;
   logic [TBL-1:0] mc_table;
   logic           c_accept, c_group;
   reason_e        c_reason;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      station_q <= STA_RESET;
      else if (sta_wr) station_q <= sta_addr;
   end

   rxf_mcast_table #(
      .LIST_W(LIST_W), .MAX_ADDR(MAX_ADDR),
      .HASH_BITS(HASH_BITS), .HASH_LSB(HASH_LSB)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .ml_start(ml_start), .ml_bytes(ml_bytes),
      .ml_byte_valid(ml_byte_valid), .ml_byte(ml_byte),
      .ml_done(ml_done), .table_o(mc_table)
   );

   rxf_classify #(
      .LEN_W(LEN_W), .HASH_BITS(HASH_BITS), .HASH_LSB(HASH_LSB)
   ) u_cls (
      .dst(chk_dst), .len(chk_len), .min_len(cfg_min_len),
      .promisc(cfg_promisc), .bcast_off(cfg_bcast_off), .mcast_en(cfg_mcast_en),
      .station(station_q), .mc_table(mc_table),
      .accept(c_accept), .group(c_group), .reason(c_reason)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_group  <= 1'b0;
         res_reason <= '0;
      end else begin
         res_valid <= chk_valid;
         if (chk_valid) begin
            res_accept <= c_accept;
            res_group  <= c_group;
            res_reason <= c_reason;
         end
      end
   end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
   parameter int LEN_W = 16,
   parameter int TBL   = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chk_valid,
   input logic [47:0]      chk_dst,
   input logic [LEN_W-1:0] chk_len,
   input logic [LEN_W-1:0] cfg_min_len,
   input logic             cfg_promisc,
   input logic             cfg_bcast_off,
   input logic             cfg_mcast_en,
   input logic             res_valid,
   input logic             res_accept,
   input logic             res_group,
   input logic [3:0]       res_reason,
   input logic             ml_start,
   input logic             ml_byte_valid,
   input logic             ml_done,
   input logic [TBL-1:0]   mc_table
);
   p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |=> res_valid);
   p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |=> !res_valid);
   p_short_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && chk_len < cfg_min_len) |=> (!res_accept && res_reason == 4'd4));
   p_promisc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && chk_len >= cfg_min_len && cfg_promisc) |=> (res_accept && !res_group));
   p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && chk_len >= cfg_min_len && !cfg_promisc && (&chk_dst))
      |=> (res_accept == !$past(cfg_bcast_off)));
   p_mc_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && chk_len >= cfg_min_len && !cfg_promisc && chk_dst[0]
       && !(&chk_dst) && !cfg_mcast_en) |=> !res_accept);
   p_group_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_group) |-> res_accept);
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ml_start |=> (mc_table == '0));
   p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ml_done |-> $past(ml_start || ml_byte_valid));
endmodule

bind rx_addr_filter rxf_checker #(.LEN_W(LEN_W), .TBL(TBL)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .chk_valid(chk_valid), .chk_dst(chk_dst), .chk_len(chk_len),
   .cfg_min_len(cfg_min_len), .cfg_promisc(cfg_promisc),
   .cfg_bcast_off(cfg_bcast_off), .cfg_mcast_en(cfg_mcast_en),
   .res_valid(res_valid), .res_accept(res_accept), .res_group(res_group),
   .res_reason(res_reason), .ml_start(ml_start), .ml_byte_valid(ml_byte_valid),
   .ml_done(ml_done), .mc_table(mc_table)
);

// File: tb/rx_addr_filter_bench.sv
`timescale 1ns/1ps
module rx_addr_filter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_promisc = 0, cfg_bcast_off = 0, cfg_mcast_en = 0;
   logic [15:0] cfg_min_len = 16'd0;
   logic        sta_wr = 0;
   logic [47:0] sta_addr = '0;
   logic        ml_start = 0;
   logic [15:0] ml_bytes = '0;
   logic        ml_byte_valid = 0;
   logic [7:0]  ml_byte = '0;
   logic        ml_done;
   logic        chk_valid = 0;
   logic [47:0] chk_dst = '0;
   logic [15:0] chk_len = '0;
   logic        res_valid, res_accept, res_group;
   logic [3:0]  res_reason;

   int n_chk = 0, n_fail = 0;
   logic [63:0] m_tbl = '0;
   logic [47:0] m_sta = '0;
   logic [47:0] lst [0:127];

   always #4 clk = ~clk;

   rx_addr_filter u_rx_addr_filter (.*);

   function automatic logic [5:0] bin_of(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         logic fb = c[0] ^ a[i];
         c = {1'b0, c[31:1]};
         if (fb) c = c ^ 32'hEDB88320;
      end
      return c[7:2];
   endfunction

   function automatic int exp_rsn(input logic [47:0] d, input logic [15:0] l);
      if (l < cfg_min_len) return 4;
      if (cfg_promisc) return 0;
      if (d == 48'hFFFF_FFFF_FFFF) return cfg_bcast_off ? 5 : 1;
      if (d[0]) begin
         if (!cfg_mcast_en) return 6;
         return m_tbl[bin_of(d)] ? 2 : 7;
      end
      return (d == m_sta) ? 3 : 8;
   endfunction

   function automatic string tag_of(input int r);
      case (r)
         4: return "R2";
         0: return "R3";
         1, 5: return "R4";
         6: return "R5";
         2, 7: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_res(input string tag, input int r);
      expect_eq({tag, " valid"}, res_valid, 1);
      expect_eq({tag, " reason"}, res_reason, r);
      expect_eq({tag, " accept"}, res_accept, (r <= 3));
      expect_eq({tag, " group"}, res_group, (r == 1 || r == 2));
   endtask

   task automatic do_check(input logic [47:0] d, input logic [15:0] l);
      int r;
      @(negedge clk);
      chk_valid = 1; chk_dst = d; chk_len = l;
      r = exp_rsn(d, l);
      @(negedge clk);
      chk_valid = 0;
      check_res(tag_of(r), r);
   endtask

   task automatic load_list(input int nbytes, input int nstream);
      int  cnt;
      bit  pend = 0, first = 1;
      @(negedge clk);
      ml_start = 1; ml_bytes = 16'(nbytes);
      @(negedge clk);
      ml_start = 0;
      cnt = nbytes / 6; if (cnt > 64) cnt = 64;
      m_tbl = '0;
      for (int a = 0; a < cnt; a++) m_tbl[bin_of(lst[a])] = 1'b1;
      if (cnt == 0) expect_eq("R9 done on empty list", ml_done, 1);
      for (int a = 0; a < nstream; a++)
         for (int b = 0; b < 6; b++) begin
            if (!first) @(negedge clk);
            first = 0;
            if (pend) begin expect_eq("R9 done pulse", ml_done, 1); pend = 0; end
            else expect_eq("R9 no early done", ml_done, 0);
            ml_byte_valid = 1; ml_byte = lst[a][8*b +: 8];
            if (a == cnt - 1 && b == 5) pend = 1;
         end
      @(negedge clk);
      ml_byte_valid = 0;
      if (pend) expect_eq("R9 done pulse", ml_done, 1);
      @(negedge clk);
      expect_eq("R9 single-cycle done", ml_done, 0);
   endtask

   function automatic logic [47:0] find_mc(input logic [63:0] avoid, input int seed);
      for (int k = seed; k < seed + 100000; k++) begin
         logic [47:0] a = {8'h00, 32'(k), 8'h01};
         if (!avoid[bin_of(a)]) return a;
      end
      return 48'h0000_0000_0001;
   endfunction

   initial begin
      logic [47:0] ma, mb, mc;
      logic [63:0] used;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      expect_eq("R1 reset res_valid", res_valid, 0);
      expect_eq("R9 reset ml_done", ml_done, 0);
      rst_n = 1;

      // R7 station write then unicast match / miss
      @(negedge clk); sta_wr = 1; sta_addr = 48'h665544332210; m_sta = sta_addr;
      @(negedge clk); sta_wr = 0;
      do_check(48'h665544332210, 16'd64);
      do_check(48'h665544332212, 16'd64);
      @(negedge clk);
      expect_eq("R1 no result without request", res_valid, 0);

      // R2 short frame beats broadcast and promiscuous
      cfg_min_len = 16'd60; cfg_promisc = 1;
      do_check(48'hFFFF_FFFF_FFFF, 16'd59);
      do_check(48'h123456789ABC, 16'd60);   // R3
      cfg_promisc = 0;
      do_check(48'hFFFF_FFFF_FFFF, 16'd60); // R4 accept
      cfg_bcast_off = 1;
      do_check(48'hFFFF_FFFF_FFFF, 16'd100); // R4 reject
      cfg_bcast_off = 0;
      do_check(48'h000000000001, 16'd100);  // R5 disabled

      // R6 load three addresses, check hits and a miss
      ma = find_mc('0, 1);
      used = '0; used[bin_of(ma)] = 1; mb = find_mc(used, 500);
      used[bin_of(mb)] = 1; mc = find_mc(used, 900);
      lst[0] = ma; lst[1] = mb; lst[2] = mc;
      cfg_mcast_en = 1;
      load_list(18, 3);
      do_check(ma, 16'd80); do_check(mb, 16'd80); do_check(mc, 16'd80);
      used[bin_of(mc)] = 1;
      do_check(find_mc(used, 3000), 16'd80);

      // R8 truncation: 13 bytes -> two addresses, third ignored
      load_list(13, 3);
      do_check(ma, 16'd80); do_check(mb, 16'd80);
      expect_eq("R8 third address ignored", exp_rsn(mc, 16'd80), 7);
      do_check(mc, 16'd80);

      // R8 cap at 64: 65th address ignored
      for (int i = 0; i < 64; i++) lst[i] = ma;
      used = '0; used[bin_of(ma)] = 1;
      lst[64] = find_mc(used, 7000);
      load_list(65 * 6, 65);
      do_check(lst[64], 16'd80);
      do_check(ma, 16'd80);

      // R8 empty list clears table
      load_list(0, 0);
      do_check(ma, 16'd80);

      // R10 request on the edge that sets its own bin
      @(negedge clk); ml_start = 1; ml_bytes = 16'd6;
      @(negedge clk); ml_start = 0;
      for (int b = 0; b < 6; b++) begin
         if (b > 0) @(negedge clk);
         ml_byte_valid = 1; ml_byte = ma[8*b +: 8];
         if (b == 5) begin chk_valid = 1; chk_dst = ma; chk_len = 16'd80; end
      end
      @(negedge clk);
      ml_byte_valid = 0; chk_valid = 0;
      check_res("R10 same-edge set sees old table", 7);
      expect_eq("R10 R9 done with collision", ml_done, 1);
      m_tbl = '0; m_tbl[bin_of(ma)] = 1;
      do_check(ma, 16'd80);

      // R10 request on the edge that clears the table
      @(negedge clk);
      ml_start = 1; ml_bytes = 16'd0;
      chk_valid = 1; chk_dst = ma; chk_len = 16'd80;
      @(negedge clk);
      ml_start = 0; chk_valid = 0;
      check_res("R10 same-edge clear sees old table", 2);
      m_tbl = '0;
      do_check(ma, 16'd80);

      // Random phase
      for (int i = 0; i < 5; i++) lst[i] = {16'($urandom), 32'($urandom)} | 48'h1;
      load_list(30, 5);
      for (int n = 0; n < 400; n++) begin
         logic [47:0] d;
         int sel = $urandom % 5;
         case (sel)
            0: d = 48'hFFFF_FFFF_FFFF;
            1: d = m_sta;
            2: d = lst[$urandom % 5];
            3: d = {16'($urandom), 32'($urandom)} | 48'h1;
            default: d = {16'($urandom), 32'($urandom)} & ~48'h1;
         endcase
         cfg_promisc   = ($urandom % 6) == 0;
         cfg_bcast_off = $urandom % 2;
         cfg_mcast_en  = ($urandom % 4) != 0;
         cfg_min_len   = 16'($urandom % 64);
         do_check(d, 16'($urandom % 96));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule